// File: doc/BRIEF.md
# Two-Stage System Watchdog Timer

This block is a countdown watchdog for a system controller. Software programs a start value, releases a halt bit and then keeps the timer alive by writing to a reload register. Time is counted in coarse ticks. A tick is a fixed number of input clocks, set by a parameter, and is about 0.6 s of real time in a typical build. On each tick the count steps down by one. The tick that finds the count already at zero is an expiry, and the count then restarts from the start value.

The first expiry is only a warning. It latches a status flag and can send a one-cycle interrupt request to a management handler. If a second expiry comes while that warning flag is still set, the block latches a second-timeout flag and a boot flag. It then drives a stretched system reset pulse, unless a no-reboot veto bit is set. The system feeds that reset back as a warm reset. The warm reset clears every register except the boot flag and the pulse stretcher, so software can see after the restart that the watchdog caused it.

All registers are reached through a flat port of 16-bit words: address, write enable and write data in, combinational read data out.

Top module: `wdog_two_stage`

## Requirements
- R1: After power-on reset the registers read as follows. The halt bit is 1 (offset 0x08 reads 0x0800). The no-reboot bit is 1 (offset 0x0C reads 0x0020). The interrupt enable, offset 0x0E, reads 0. Both status words, 0x04 and 0x06, read 0. The start value, 0x12, reads 0x0004. The count, 0x00, reads 4.
- R2: The start-value register at 0x12 reads back all 16 written bits, and only bits [9:0] are used as the count. A write whose bits [9:0] are below 4 is dropped entirely, and the previous value stays.
- R3: Any write to offset 0x00 loads the count from start-value bits [9:0] and restarts the tick divider. A read of 0x00 returns the live count in bits [9:0]. A reload in the same cycle as a would-be expiry cancels that expiry.
- R4: While the halt bit (0x08 bit 11) is 1, the count and the tick divider do not advance.
- R5: While running, the count steps down once every TICK_DIV clocks. The tick that finds the count at 0 is an expiry and reloads the start value, so an expiry follows start+1 ticks after a reload.
- R6: An expiry while the warning flag (0x04 bit 3) is clear sets that flag. In the following cycle it drives irq_o high for one cycle, but only if the interrupt-enable bit (0x0E bit 13) is 1.
- R7: An expiry while the warning flag is set sets both the second-timeout flag (0x06 bit 1) and the boot flag (0x06 bit 2).
- R8: A second expiry with the no-reboot bit (0x0C bit 5) clear drives sys_rst_o high for exactly RST_LEN cycles, starting the cycle after the expiry. With the bit set, sys_rst_o stays low.
- R9: The status bits are write-1-to-clear, and a 0 written to a bit leaves it unchanged. When a flag is set and cleared in the same cycle, the set wins.
- R10: A warm reset (warm_n low) returns every register to its R1 value except the boot flag and the reset stretcher. Power-on reset (por_n low) clears everything.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| warm_n | input | 1 | Warm system reset, active low, synchronous; the boot flag and stretcher keep their state |
| host_addr | input | ADDR_W | Register word offset |
| host_we | input | 1 | Write strobe, one write per cycle |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data for host_addr, combinational |
| irq_o | output | 1 | One-cycle interrupt request on the first expiry |
| sys_rst_o | output | 1 | Stretched system reset request on the second expiry |

## Verification
Two pairs of functions can land in the same cycle. An expiry can meet a host write that clears the warning flag, and an expiry can meet a reload write. To provoke each collision, the bench watches its reference model. When the model shows a zero count with the divider on its last step, the bench issues the write on that very edge. Set-over-clear is judged by the warning flag still reading 1 after the cleared-and-set edge. Reload-over-expiry is judged by the status word staying 0 and the count reading the start value.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam int unsigned DATA_W = 16;

  // Register word offsets
  localparam logic [4:0] OFS_RELOAD = 5'h00;
  localparam logic [4:0] OFS_STS_A  = 5'h04;
  localparam logic [4:0] OFS_STS_B  = 5'h06;
  localparam logic [4:0] OFS_CTRL   = 5'h08;
  localparam logic [4:0] OFS_GCTL   = 5'h0C;
  localparam logic [4:0] OFS_IEN    = 5'h0E;
  localparam logic [4:0] OFS_START  = 5'h12;

  // Bit positions
  localparam int unsigned B_WARN   = 3;
  localparam int unsigned B_SECOND = 1;
  localparam int unsigned B_BOOT   = 2;
  localparam int unsigned B_HALT   = 11;
  localparam int unsigned B_NORB   = 5;
  localparam int unsigned B_IEN    = 13;

  // A start value is usable only at or above the floor
  function automatic logic start_ok(input int unsigned v, input int unsigned floor_v);
    return v >= floor_v;
  endfunction

  // Sticky flag: a set event beats a clear request in the same cycle
  function automatic logic flag_next(input logic cur, input logic set_ev, input logic clr_req);
    return set_ev | (cur & ~clr_req);
  endfunction

  // Next value of a down-counter that wraps to a reload value
  function automatic logic [15:0] count_next(input logic [15:0] cur, input logic [15:0] wrap_v);
    return (cur == 16'd0) ? wrap_v : cur - 16'd1;
  endfunction

endpackage

// File: rtl/wdog_tick.sv
module wdog_tick #(
  parameter int unsigned TICK_DIV = 30_000_000
) (
  input  logic clk,
  input  logic srst,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int unsigned DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);

  generate
    if (TICK_DIV <= 1) begin : g_direct
      assign tick = run & ~restart;
    end else begin : g_div
      logic [DW-1:0] div_q;
      logic          at_last;
      assign at_last = (div_q == LAST);
      assign tick    = run & at_last;

      always_ff @(posedge clk) begin
        if (srst || !run || restart || at_last) div_q <= '0;
        else                                    div_q <= div_q + 1'b1;
      end

      assert_div_bound_R5: assert property (@(posedge clk) disable iff (srst)
        div_q <= LAST);
      assert_div_frozen_R4: assert property (@(posedge clk) disable iff (srst)
        !run |=> div_q == '0);
    end
  endgenerate
endmodule

// File: rtl/wdog_down.sv
module wdog_down #(
  parameter int unsigned CNT_W = 10,
  parameter int unsigned RESET_VAL = 4
) (
  input  logic             clk,
  input  logic             srst,
  input  logic             tick,
  input  logic             reload,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire,
  output logic [CNT_W-1:0] count
);
  import wdog_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic [15:0]      stepped;

  assign stepped = count_next(16'(cnt_q), 16'(load_val));
  assign expire  = tick & (cnt_q == '0) & ~reload;
  assign count   = cnt_q;

  always_ff @(posedge clk) begin
    if (srst)        cnt_q <= CNT_W'(RESET_VAL);
    else if (reload) cnt_q <= load_val;
    else if (tick)   cnt_q <= stepped[CNT_W-1:0];
  end

  assert_step_down_R5: assert property (@(posedge clk) disable iff (srst)
    (tick && !reload && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
  assert_hold_no_tick_R4: assert property (@(posedge clk) disable iff (srst)
    (!tick && !reload) |=> $stable(cnt_q));
  assert_reload_load_R3: assert property (@(posedge clk) disable iff (srst)
    reload |=> cnt_q == $past(load_val));
endmodule

// File: rtl/wdog_flags.sv
module wdog_flags #(
  parameter int unsigned RST_LEN = 16
) (
  input  logic clk,
  input  logic por_srst,
  input  logic warm_srst,
  input  logic expire,
  input  logic clr_warn,
  input  logic clr_second,
  input  logic clr_boot,
  input  logic irq_en,
  input  logic no_reboot,
  output logic warn_q,
  output logic second_q,
  output logic boot_q,
  output logic irq_o,
  output logic sys_rst_o
);
  import wdog_pkg::*;

  localparam int unsigned RW = $clog2(RST_LEN + 1);

  logic          first_ev;
  logic          second_ev;
  logic          fire_rst;
  logic [RW-1:0] stretch_q;
  logic          any_srst;

  assign any_srst  = por_srst | warm_srst;
  assign first_ev  = expire & ~warn_q;
  assign second_ev = expire & warn_q;
  assign fire_rst  = second_ev & ~no_reboot & ~warm_srst;
  assign sys_rst_o = (stretch_q != '0);

  always_ff @(posedge clk) begin
    if (any_srst) begin
      warn_q   <= 1'b0;
      second_q <= 1'b0;
      irq_o    <= 1'b0;
    end else begin
      warn_q   <= flag_next(warn_q, first_ev, clr_warn);
      second_q <= flag_next(second_q, second_ev, clr_second);
      irq_o    <= first_ev & irq_en;
    end
  end

  // Boot flag and stretcher live in the power-on domain
  always_ff @(posedge clk) begin
    if (por_srst) begin
      boot_q    <= 1'b0;
      stretch_q <= '0;
    end else begin
      if (!warm_srst) boot_q <= flag_next(boot_q, second_ev, clr_boot);
      if (fire_rst)               stretch_q <= RW'(RST_LEN);
      else if (stretch_q != '0)   stretch_q <= stretch_q - 1'b1;
    end
  end

  assert_irq_with_warn_R6: assert property (@(posedge clk) disable iff (any_srst)
    irq_o |-> warn_q);
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (any_srst)
    first_ev |=> warn_q);
  assert_rst_marks_boot_R7: assert property (@(posedge clk) disable iff (por_srst)
    $rose(sys_rst_o) |-> boot_q);
  assert_veto_R8: assert property (@(posedge clk) disable iff (any_srst)
    (second_ev && no_reboot && !sys_rst_o) |=> !sys_rst_o);
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage #(
  parameter int unsigned TICK_DIV   = 30_000_000,
  parameter int unsigned RST_LEN    = 16,
  parameter int unsigned CNT_W      = 10,
  parameter int unsigned ADDR_W     = 5,
  parameter int unsigned START_RST  = 4,
  parameter int unsigned START_MIN  = 4
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              warm_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_we,
  input  logic [15:0]       host_wdata,
  output logic [15:0]       host_rdata,
  output logic              irq_o,
  output logic              sys_rst_o
);
  import wdog_pkg::*;

  localparam logic [15:0] START_RST_W = 16'(START_RST);

  logic por_srst, warm_srst, srst;
  assign por_srst  = ~por_n;
  assign warm_srst = ~warm_n;
  assign srst      = por_srst | warm_srst;

  // Host write decode
  logic [4:0] a5;
  assign a5 = 5'(host_addr);

  logic wr_reload, wr_sts_a, wr_sts_b, wr_ctrl, wr_gctl, wr_ien, wr_start, start_accept;
  assign wr_reload    = host_we & (a5 == OFS_RELOAD);
  assign wr_sts_a     = host_we & (a5 == OFS_STS_A);
  assign wr_sts_b     = host_we & (a5 == OFS_STS_B);
  assign wr_ctrl      = host_we & (a5 == OFS_CTRL);
  assign wr_gctl      = host_we & (a5 == OFS_GCTL);
  assign wr_ien       = host_we & (a5 == OFS_IEN);
  assign wr_start     = host_we & (a5 == OFS_START);
  assign start_accept = wr_start & start_ok(32'(host_wdata[CNT_W-1:0]), START_MIN);

  // Control registers
  logic        halt_q, norb_q, ien_q;
  logic [15:0] start_q;

  always_ff @(posedge clk) begin
    if (srst) begin
      halt_q  <= 1'b1;
      norb_q  <= 1'b1;
      ien_q   <= 1'b0;
      start_q <= START_RST_W;
    end else begin
      if (wr_ctrl)      halt_q  <= host_wdata[B_HALT];
      if (wr_gctl)      norb_q  <= host_wdata[B_NORB];
      if (wr_ien)       ien_q   <= host_wdata[B_IEN];
      if (start_accept) start_q <= host_wdata;
    end
  end

  // Datapath
  logic             tick, expire;
  logic [CNT_W-1:0] count;
  logic             warn_q, second_q, boot_q;

  wdog_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk     (clk),
    .srst    (srst),
    .run     (~halt_q),
    .restart (wr_reload),
    .tick    (tick)
  );

  wdog_down #(.CNT_W(CNT_W), .RESET_VAL(START_RST)) u_down (
    .clk      (clk),
    .srst     (srst),
    .tick     (tick),
    .reload   (wr_reload),
    .load_val (start_q[CNT_W-1:0]),
    .expire   (expire),
    .count    (count)
  );

  wdog_flags #(.RST_LEN(RST_LEN)) u_flags (
    .clk        (clk),
    .por_srst   (por_srst),
    .warm_srst  (warm_srst),
    .expire     (expire),
    .clr_warn   (wr_sts_a & host_wdata[B_WARN]),
    .clr_second (wr_sts_b & host_wdata[B_SECOND]),
    .clr_boot   (wr_sts_b & host_wdata[B_BOOT]),
    .irq_en     (ien_q),
    .no_reboot  (norb_q),
    .warn_q     (warn_q),
    .second_q   (second_q),
    .boot_q     (boot_q),
    .irq_o      (irq_o),
    .sys_rst_o  (sys_rst_o)
  );

  // Read mux
  always_comb begin
    host_rdata = '0;
    case (a5)
      OFS_RELOAD: host_rdata[CNT_W-1:0] = count;
      OFS_STS_A:  host_rdata[B_WARN]    = warn_q;
      OFS_STS_B: begin
        host_rdata[B_SECOND] = second_q;
        host_rdata[B_BOOT]   = boot_q;
      end
      OFS_CTRL:   host_rdata[B_HALT]    = halt_q;
      OFS_GCTL:   host_rdata[B_NORB]    = norb_q;
      OFS_IEN:    host_rdata[B_IEN]     = ien_q;
      OFS_START:  host_rdata            = start_q;
      default:    host_rdata            = '0;
    endcase
  end

  assert_start_reject_R2: assert property (@(posedge clk) disable iff (srst)
    (wr_start && !start_accept) |=> $stable(start_q));
  assert_halt_no_expire_R4: assert property (@(posedge clk) disable iff (srst)
    halt_q |-> !expire);
  assert_reload_cancels_R3: assert property (@(posedge clk) disable iff (srst)
    wr_reload |-> !expire);
  assert_warm_clears_R10: assert property (@(posedge clk) disable iff (por_srst)
    warm_srst |=> (halt_q && norb_q && !warn_q && !second_q));
endmodule

// File: tb/sim_wdog_two_stage.sv
module sim_wdog_two_stage;
  localparam int DIV = 3;
  localparam int RLEN = 4;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        bwarm = 1'b1;
  logic [4:0]  addr = '0;
  logic        we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq, srst_out, warm_n;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  assign warm_n = bwarm & ~srst_out;

  wdog_two_stage #(.TICK_DIV(DIV), .RST_LEN(RLEN)) u0 (
    .clk(clk), .por_n(por_n), .warm_n(warm_n), .host_addr(addr), .host_we(we),
    .host_wdata(wdata), .host_rdata(rdata), .irq_o(irq), .sys_rst_o(srst_out)
  );

  // Behavioural reference model
  int          m_div, m_cnt, m_rcnt;
  logic [15:0] m_start;
  bit          m_halt, m_norb, m_ien, m_warn, m_sec, m_boot, m_irq;

  task automatic m_warm_reset();
    m_div = 0; m_cnt = 4; m_start = 16'h0004; m_halt = 1; m_norb = 1; m_ien = 0;
    m_warn = 0; m_sec = 0; m_irq = 0;
  endtask

  always @(posedge clk) begin
    if (!por_n) begin
      m_warm_reset(); m_boot = 0; m_rcnt = 0;
    end else if (!(bwarm && m_rcnt == 0)) begin
      m_warm_reset();
      if (m_rcnt > 0) m_rcnt--;
    end else begin
      bit rl, tk, ex, ev1, ev2;
      rl  = we && addr == 5'h00;
      tk  = !m_halt && m_div == DIV - 1;
      ex  = tk && m_cnt == 0 && !rl;
      ev1 = ex && !m_warn;
      ev2 = ex && m_warn;
      m_irq = ev1 && m_ien;
      if (ev2 && !m_norb) m_rcnt = RLEN;
      m_warn = ev1 || (m_warn && !(we && addr == 5'h04 && wdata[3]));
      m_sec  = ev2 || (m_sec  && !(we && addr == 5'h06 && wdata[1]));
      m_boot = ev2 || (m_boot && !(we && addr == 5'h06 && wdata[2]));
      if (rl) m_cnt = m_start[9:0];
      else if (tk) m_cnt = (m_cnt == 0) ? int'(m_start[9:0]) : m_cnt - 1;
      m_div = (m_halt || rl || tk) ? 0 : m_div + 1;
      if (we && addr == 5'h08) m_halt = wdata[11];
      if (we && addr == 5'h0C) m_norb = wdata[5];
      if (we && addr == 5'h0E) m_ien  = wdata[13];
      if (we && addr == 5'h12 && wdata[9:0] >= 4) m_start = wdata;
    end
  end

  function automatic logic [15:0] m_read(input logic [4:0] a);
    case (a)
      5'h00: return 16'(m_cnt);
      5'h04: return {12'd0, m_warn, 3'd0};
      5'h06: return {13'd0, m_boot, m_sec, 1'b0};
      5'h08: return 16'(m_halt) << 11;
      5'h0C: return 16'(m_norb) << 5;
      5'h0E: return 16'(m_ien) << 13;
      5'h12: return m_start;
      default: return 16'h0;
    endcase
  endfunction

  // Per-clock comparison against the model
  always @(posedge clk) begin
    #5;
    n_chk++;
    if (rdata !== m_read(addr) || irq !== m_irq || srst_out !== (m_rcnt != 0)) begin
      n_bad++;
      if (rdata !== m_read(addr))
        $display("FAIL R3 model rdata@%h actual=%h expected=%h", addr, rdata, m_read(addr));
      if (irq !== m_irq)
        $display("FAIL R6 model irq actual=%b expected=%b", irq, m_irq);
      if (srst_out !== (m_rcnt != 0))
        $display("FAIL R8 model sys_rst actual=%b expected=%b", srst_out, m_rcnt != 0);
    end
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_now(input logic [4:0] a, input logic [15:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_now(a, d);
  endtask

  task automatic rd(input logic [4:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    addr = a;
    #2;
    check(tag, rdata, exp);
  endtask

  // Returns at the negedge just before the edge on which an expiry occurs
  task automatic wait_expiry();
    forever begin
      @(negedge clk);
      if (!m_halt && m_div == DIV - 1 && m_cnt == 0) break;
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    int hi;
    repeat (3) @(negedge clk);
    por_n = 1'b1;

    // R1 reset state
    rd(5'h08, 16'h0800, "R1 halt");
    rd(5'h0C, 16'h0020, "R1 no-reboot");
    rd(5'h0E, 16'h0000, "R1 irq enable");
    rd(5'h04, 16'h0000, "R1 status A");
    rd(5'h06, 16'h0000, "R1 status B");
    rd(5'h12, 16'h0004, "R1 start");
    rd(5'h00, 16'h0004, "R1 count");

    // R2 start value filtering and full readback
    wr(5'h12, 16'h0003);
    rd(5'h12, 16'h0004, "R2 reject 3");
    wr(5'h12, 16'hA805);
    rd(5'h12, 16'hA805, "R2 accept raw");

    // R3 reload, R4 halted
    wr(5'h00, 16'h0000);
    rd(5'h00, 16'h0005, "R3 reload count");
    repeat (12) @(negedge clk);
    rd(5'h00, 16'h0005, "R4 halted count");

    // R5 / R6 first expiry with interrupt enabled
    wr(5'h0E, 16'h2000);
    wr(5'h08, 16'h0000);
    wait_expiry();
    @(negedge clk);
    addr = 5'h00; #2;
    check("R6 irq pulse", 16'(irq), 16'h1);
    check("R5 reload at expiry", rdata, 16'h0005);
    repeat (3) @(negedge clk);
    #2;
    check("R5 one tick later", rdata, 16'h0004);
    rd(5'h04, 16'h0008, "R6 warn flag");

    // R9 writing 0 has no effect
    wr(5'h04, 16'h0000);
    rd(5'h04, 16'h0008, "R9 zero write keeps");

    // R7 / R8 second expiry with veto
    wait_expiry();
    @(negedge clk);
    addr = 5'h06; #2;
    check("R7 second+boot", rdata, 16'h0006);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R8 vetoed reset", 16'(srst_out), 16'h0);
    end

    // R9 selective clears
    wr(5'h06, 16'h0002);
    rd(5'h06, 16'h0004, "R9 clear second only");
    wr(5'h06, 16'h0004);
    rd(5'h06, 16'h0000, "R9 clear boot");
    wr(5'h04, 16'h0008);
    rd(5'h04, 16'h0000, "R9 clear warn");

    // R9 collision: clear in the expiry cycle, set wins
    wait_expiry();
    wr_now(5'h04, 16'h0008);
    rd(5'h04, 16'h0008, "R9 set beats clear");
    wr(5'h04, 16'h0008);

    // R3 collision: reload in the expiry cycle cancels it
    wait_expiry();
    wr_now(5'h00, 16'h0000);
    addr = 5'h04; #2;
    check("R3 reload cancels expiry", rdata, 16'h0000);
    rd(5'h00, 16'h0005, "R3 count after cancel");

    // R6 interrupt gated off
    wr(5'h0E, 16'h0000);
    wait_expiry();
    @(negedge clk);
    check("R6 irq gated", 16'(irq), 16'h0);
    rd(5'h04, 16'h0008, "R6 flag without irq");

    // R8 / R10 real reset path
    wr(5'h0C, 16'h0000);
    wait_expiry();
    @(negedge clk);
    check("R8 reset asserted", 16'(srst_out), 16'h1);
    hi = 0;
    while (srst_out) begin
      hi++;
      @(negedge clk);
    end
    check("R8 pulse length", 16'(hi), 16'(RLEN));
    addr = 5'h08; #2;
    check("R10 halt after warm", rdata, 16'h0800);
    rd(5'h0C, 16'h0020, "R10 no-reboot after warm");
    rd(5'h06, 16'h0004, "R10 boot survives");
    rd(5'h04, 16'h0000, "R10 warn cleared");
    rd(5'h12, 16'h0004, "R10 start restored");

    // R10 power-on clears boot
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    rd(5'h06, 16'h0000, "R10 por clears boot");

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule